// File: doc/BRIEF.md
# Keyed Write-Protection Gate

The gate sits between the latched write path and the page write sequencer. It receives each write as a single-cycle strobe that carries an address and a data byte. For every write it returns one registered decision. The decision tells the page buffer whether to store the byte, or only to retrigger the programming timer and drop the data. The gate also holds a nonvolatile protection flag, which it reports on a status output.

While the flag is set, the gate stores data only after an authorizing run of three key writes. The writes that follow that run, to any address, are stored as one page until the sequencer signals the end of the write period. The same three-write run, issued while the flag is clear, sets the flag at the end of the following write period. A six-write run clears the flag at the end of the following write period. In both cases no data bytes need to follow.

Key writes are never stored. A write that breaks a partial run cancels it. The matcher then treats that same write as a possible first key. Only the low 16 address bits take part in key comparison.

Top module: `wp_unlock_gate`

## Requirements
- R1: `prot_on` is 0 after power-up, and asserting `rst` does not change its value.
- R2: With the flag clear, a write that is not a key write produces `dec_accept`=1 on the clock edge after its strobe, with `dec_addr`/`dec_data` equal to the write's address and data.
- R3: Every write strobe, whether a key, stored or discarded write, produces `dec_valid`=1 on exactly the next edge. `dec_valid` is 0 in every other cycle.
- R4: A write that is consumed as a key step gets `dec_accept`=0.
- R5: The run data A0h@5555h, preceded by 55h@2AAAh and AAh@5555h (in the order AA, 55, A0), with the flag clear, sets `prot_on` on the edge that samples the next `prog_done` pulse, with no data writes needed.
- R6: With the flag set and no authorizing run open, every write gets `dec_valid`=1 and `dec_accept`=0.
- R7: With the flag set, after the three-key run every write up to the next `prog_done` is accepted, key-like ones (AAh@5555h) included. After that `prog_done`, writes are discarded again and the flag stays set.
- R8: The six-write run AAh@5555h, 55h@2AAAh, 80h@5555h, AAh@5555h, 55h@2AAAh, 20h@5555h clears `prot_on` at the next `prog_done`. Writes following the run are accepted.
- R9: A write that breaks a partial run cancels it. If that write is AAh@5555h it starts a new run; otherwise it is judged as an ordinary write.
- R10: Address bits at or above bit 16 are ignored in key comparison (AAh@15555h is a first key).
- R11: `prot_on` changes only on an edge where `prog_done` is sampled high after a completed run. A `prog_done` with no completed run leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; does not touch the protection flag |
| wr_valid | input | 1 | One-cycle strobe of a latched write |
| wr_addr | input | ADDR_W (17) | Write address |
| wr_data | input | DATA_W (8) | Write data |
| prog_done | input | 1 | End of the write period, from the page sequencer |
| dec_valid | output | 1 | Decision present: retrigger the programming timer |
| dec_accept | output | 1 | Store this byte in the page buffer |
| dec_addr | output | ADDR_W (17) | Address of the decided write |
| dec_data | output | DATA_W (8) | Data of the decided write |
| prot_on | output | 1 | Protection flag |

## Verification
Each write decision is due on the first rising edge after the strobe. The bench drives the strobe on a falling edge and reads `dec_valid`, `dec_accept`, `dec_addr` and `dec_data` on the next falling edge. A flag change is due on the edge that samples `prog_done`, so the bench pulses `prog_done` for one falling-to-falling interval and reads `prot_on` at the end of it. The bench also reads `prot_on` just before each pulse, to show the flag did not move early.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int KEY_AW = 16;
  localparam logic [KEY_AW-1:0] KADDR_HI = 16'h5555;
  localparam logic [KEY_AW-1:0] KADDR_LO = 16'h2AAA;
  localparam logic [7:0] KD_FIRST  = 8'hAA;
  localparam logic [7:0] KD_SECOND = 8'h55;
  localparam logic [7:0] KD_LOCK   = 8'hA0;
  localparam logic [7:0] KD_EXT    = 8'h80;
  localparam logic [7:0] KD_CLEAR  = 8'h20;

  typedef enum logic [2:0] {
    ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5
  } wp_step_e;
endpackage

// File: rtl/wp_key_matcher.sv
module wp_key_matcher
  import wp_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [KEY_AW-1:0] key_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              hold,
  output logic              key_hit,
  output logic              lock_done,
  output logic              clear_done
);
  wp_step_e step_q, step_d;
  logic at_hi, at_lo, is_first;

  always_comb begin
    at_hi    = (key_addr == KADDR_HI);
    at_lo    = (key_addr == KADDR_LO);
    is_first = at_hi && (wr_data == DATA_W'(KD_FIRST));
  end

  always_comb begin
    step_d     = step_q;
    key_hit    = 1'b0;
    lock_done  = 1'b0;
    clear_done = 1'b0;
    if (wr_valid && !hold) begin
      case (step_q)
        ST_K1: if (at_lo && wr_data == DATA_W'(KD_SECOND)) begin
          step_d = ST_K2; key_hit = 1'b1;
        end
        ST_K2: if (at_hi && wr_data == DATA_W'(KD_LOCK)) begin
          step_d = ST_IDLE; key_hit = 1'b1; lock_done = 1'b1;
        end else if (at_hi && wr_data == DATA_W'(KD_EXT)) begin
          step_d = ST_K3; key_hit = 1'b1;
        end
        ST_K3: if (is_first) begin
          step_d = ST_K4; key_hit = 1'b1;
        end
        ST_K4: if (at_lo && wr_data == DATA_W'(KD_SECOND)) begin
          step_d = ST_K5; key_hit = 1'b1;
        end
        ST_K5: if (at_hi && wr_data == DATA_W'(KD_CLEAR)) begin
          step_d = ST_IDLE; key_hit = 1'b1; clear_done = 1'b1;
        end
        default: ;
      endcase
      if (!key_hit) begin
        if (is_first) begin
          step_d  = ST_K1;
          key_hit = 1'b1;
        end else begin
          step_d = ST_IDLE;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) step_q <= ST_IDLE;
    else     step_q <= step_d;
  end
endmodule

// File: rtl/wp_prot_state.sv
module wp_prot_state (
  input  logic clk,
  input  logic rst,
  input  logic lock_done,
  input  logic clear_done,
  input  logic prog_done,
  output logic prot_on,
  output logic win_open
);
  logic prot_q = 1'b0;
  logic win_q;
  logic pend_val_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      win_q      <= 1'b0;
      pend_val_q <= 1'b0;
    end else if (lock_done || clear_done) begin
      win_q      <= 1'b1;
      pend_val_q <= lock_done ? 1'b1 : (clear_done ? 1'b0 : prot_q);
    end else if (prog_done) begin
      win_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && prog_done && win_q)
      prot_q <= pend_val_q;
  end

  assign prot_on  = prot_q;
  assign win_open = win_q;
endmodule

// File: rtl/wp_decision_reg.sv
module wp_decision_reg #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic              accept,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [DATA_W-1:0] dec_data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dec_valid  <= 1'b0;
      dec_accept <= 1'b0;
      dec_addr   <= '0;
      dec_data   <= '0;
    end else begin
      dec_valid  <= wr_valid;
      dec_accept <= wr_valid && accept;
      if (wr_valid) begin
        dec_addr <= wr_addr;
        dec_data <= wr_data;
      end
    end
  end
endmodule

// File: rtl/wp_unlock_gate.sv
module wp_unlock_gate
  import wp_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_valid,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              prog_done,
  output logic              dec_valid,
  output logic              dec_accept,
  output logic [ADDR_W-1:0] dec_addr,
  output logic [DATA_W-1:0] dec_data,
  output logic              prot_on
);
  logic key_hit, lock_done, clear_done, win_open, accept;
  logic [KEY_AW-1:0] key_addr;

  assign key_addr = wr_addr[KEY_AW-1:0];

  wp_key_matcher #(.DATA_W(DATA_W)) u_match (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .key_addr(key_addr),
    .wr_data(wr_data), .hold(win_open), .key_hit(key_hit),
    .lock_done(lock_done), .clear_done(clear_done)
  );

  wp_prot_state u_state (
    .clk(clk), .rst(rst), .lock_done(lock_done), .clear_done(clear_done),
    .prog_done(prog_done), .prot_on(prot_on), .win_open(win_open)
  );

  assign accept = win_open || (!key_hit && !prot_on);

  wp_decision_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .accept(accept),
    .wr_addr(wr_addr), .wr_data(wr_data), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_addr(dec_addr), .dec_data(dec_data)
  );
endmodule

// File: rtl/wp_unlock_gate_chk.sv
module wp_unlock_gate_chk #(
  parameter int ADDR_W = 17
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_valid,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              prog_done,
  input logic              dec_valid,
  input logic              dec_accept,
  input logic [ADDR_W-1:0] dec_addr,
  input logic              prot_on,
  input logic              win_open,
  input logic              key_hit
);
  AST_DEC_FOLLOWS_WR: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> dec_valid); // R3
  AST_NO_SPURIOUS_DEC: assert property (@(posedge clk) disable iff (rst)
    !wr_valid |=> !dec_valid); // R3
  AST_ADDR_ECHO: assert property (@(posedge clk) disable iff (rst)
    wr_valid |=> dec_addr == $past(wr_addr)); // R2
  AST_KEY_DROPPED: assert property (@(posedge clk) disable iff (rst)
    wr_valid && key_hit |=> !dec_accept); // R4
  AST_LOCKED_DISCARD: assert property (@(posedge clk) disable iff (rst)
    wr_valid && prot_on && !win_open |=> !dec_accept); // R6
  AST_PROT_HELD: assert property (@(posedge clk) disable iff (rst)
    !prog_done |=> $stable(prot_on)); // R11
endmodule

bind wp_unlock_gate wp_unlock_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
  .prog_done(prog_done), .dec_valid(dec_valid), .dec_accept(dec_accept),
  .dec_addr(dec_addr), .prot_on(prot_on), .win_open(win_open),
  .key_hit(key_hit)
);

// File: tb/tb_wp_unlock_gate.sv
module tb_wp_unlock_gate;
  localparam int CLK_P  = 10;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_valid = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0;
  logic [DATA_W-1:0] wr_data = '0;
  logic prog_done = 1'b0;
  logic dec_valid, dec_accept, prot_on;
  logic [ADDR_W-1:0] dec_addr;
  logic [DATA_W-1:0] dec_data;

  int n_chk = 0;
  int n_err = 0;

  always #(CLK_P/2) clk = ~clk;

  wp_unlock_gate #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut (
    .clk(clk), .rst(rst), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .prog_done(prog_done), .dec_valid(dec_valid),
    .dec_accept(dec_accept), .dec_addr(dec_addr), .dec_data(dec_data),
    .prot_on(prot_on)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one write on a falling edge, read its decision one edge later
  task automatic wr(string req, logic [ADDR_W-1:0] a, logic [7:0] d, logic exp_acc);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    check({req, " valid"}, 32'(dec_valid), 32'd1);
    check({req, " accept"}, 32'(dec_accept), 32'(exp_acc));
    if (exp_acc) begin
      check({req, " addr"}, 32'(dec_addr), 32'(a));
      check({req, " data"}, 32'(dec_data), 32'(d));
    end
  endtask

  task automatic done_pulse(string req, logic exp_before, logic exp_after);
    @(negedge clk);
    check({req, " flag before end"}, 32'(prot_on), 32'(exp_before));
    prog_done = 1'b1;
    @(negedge clk);
    prog_done = 1'b0;
    check({req, " flag after end"}, 32'(prot_on), 32'(exp_after));
  endtask

  task automatic lock_prefix(string req, logic [ADDR_W-1:0] hi, logic [ADDR_W-1:0] lo);
    wr(req, hi, 8'hAA, 1'b0);
    wr(req, lo, 8'h55, 1'b0);
    wr(req, hi, 8'hA0, 1'b0);
  endtask

  task automatic t_reset();
    check("R1 flag at power-up", 32'(prot_on), 32'd0);
    check("R3 no decision in reset", 32'(dec_valid), 32'd0);
  endtask

  task automatic t_plain();
    wr("R2 plain write a", 17'h00010, 8'h3C, 1'b1);
    wr("R2 plain write b", 17'h1FFFF, 8'hFF, 1'b1);
    wr("R2 plain write c", 17'h05555, 8'h55, 1'b1);
    @(negedge clk);
    check("R3 idle cycle no decision", 32'(dec_valid), 32'd0);
  endtask

  task automatic t_break();
    wr("R4 first key dropped", 17'h05555, 8'hAA, 1'b0);
    wr("R4 second key dropped", 17'h02AAA, 8'h55, 1'b0);
    wr("R9 breaking write stored", 17'h00040, 8'h33, 1'b1);
    wr("R9 run cancelled, second key is data", 17'h02AAA, 8'h55, 1'b1);
  endtask

  task automatic t_lock();
    lock_prefix("R5 lock run", 17'h05555, 17'h02AAA);
    done_pulse("R5", 1'b0, 1'b1);
  endtask

  task automatic t_reset_keeps();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    check("R1 reset keeps flag", 32'(prot_on), 32'd1);
  endtask

  task automatic t_discard();
    wr("R6 locked write discarded", 17'h00010, 8'h5A, 1'b0);
    wr("R6 locked write discarded 2", 17'h1F000, 8'h01, 1'b0);
    done_pulse("R11 end without run", 1'b1, 1'b1);
  endtask

  task automatic t_auth_page();
    lock_prefix("R7 auth run", 17'h05555, 17'h02AAA);
    wr("R7 page byte 0", 17'h00200, 8'h11, 1'b1);
    wr("R7 key-like byte is data", 17'h05555, 8'hAA, 1'b1);
    wr("R7 page byte 2", 17'h00202, 8'h22, 1'b1);
    done_pulse("R7", 1'b1, 1'b1);
    wr("R7 discarded after page", 17'h00203, 8'h44, 1'b0);
  endtask

  task automatic t_restart();
    wr("R9 key1", 17'h05555, 8'hAA, 1'b0);
    wr("R9 key2", 17'h02AAA, 8'h55, 1'b0);
    wr("R9 restart on AA", 17'h05555, 8'hAA, 1'b0);
    wr("R9 key2 again", 17'h02AAA, 8'h55, 1'b0);
    wr("R9 key3", 17'h05555, 8'hA0, 1'b0);
    wr("R9 page byte after restart", 17'h00100, 8'h66, 1'b1);
    done_pulse("R9", 1'b1, 1'b1);
  endtask

  task automatic t_upper_addr();
    lock_prefix("R10 high-bank keys", 17'h15555, 17'h12AAA);
    wr("R10 page byte", 17'h10000, 8'h99, 1'b1);
    done_pulse("R10", 1'b1, 1'b1);
  endtask

  task automatic t_clear();
    wr("R8 c1", 17'h05555, 8'hAA, 1'b0);
    wr("R8 c2", 17'h02AAA, 8'h55, 1'b0);
    wr("R8 c3", 17'h05555, 8'h80, 1'b0);
    wr("R8 c4", 17'h05555, 8'hAA, 1'b0);
    wr("R8 c5", 17'h02AAA, 8'h55, 1'b0);
    wr("R8 c6", 17'h05555, 8'h20, 1'b0);
    wr("R8 byte after clear run", 17'h00300, 8'h77, 1'b1);
    done_pulse("R8", 1'b1, 1'b0);
    wr("R8 open write after clear", 17'h00301, 8'h78, 1'b1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_plain();
    t_break();
    t_lock();
    t_reset_keeps();
    t_discard();
    t_auth_page();
    t_restart();
    t_upper_addr();
    t_clear();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule